// File: doc/BRIEF.md
# Four-Slot Receive Frame Writer

This block takes a received Ethernet payload, presented as a length followed by a stream of bytes, and stores a complete wire-format copy of it in host memory. The copy opens with seven 0x55 bytes and the 0xD5 delimiter, continues with the payload, is zero-filled up to the minimum payload size, and closes with a CRC-32 frame check sequence. Bytes leave on a byte-wide memory write port, addressed from the base address of the chosen buffer.

The host offers up to four buffers. Each one has a two-bit state, a base address and a length field, and these registers live outside the block. The block reads the states and bases as inputs. It picks the lowest-numbered buffer the host has marked as loaded. When the frame is complete, it strobes a length and a new state into that buffer's registers and raises a one-cycle receive interrupt. Frames are dropped silently in three cases: receive reset is held, no buffer is loaded, or the framed result would be too long. Their bytes are still consumed, so the source never stalls.

Top module: `rx_slot_writer`

## Requirements
- R1: Each buffer's state field encodes 0 as empty, 1 as loaded and 2 as pending. A frame goes to the lowest-numbered buffer whose state is 1.
- R2: When no buffer state is 1, the frame is dropped. There are no memory writes, no buffer update and no interrupt, and every payload byte is still accepted.
- R3: While `rx_hold` is high when a frame starts, the frame is dropped in the same way as in R2, whatever the buffer states.
- R4: The first eight bytes are written to base+0 through base+7. Bytes 0 to 6 are 0x55 and byte 7 is 0xD5.
- R5: Payload byte k is written to base+8+k, in arrival order. At most one byte is accepted per cycle, and only while `in_ready` is high.
- R6: A payload shorter than 60 bytes is followed by zero bytes until 60 payload bytes have been written.
- R7: The four bytes after the padded payload hold the CRC-32 of the padded payload only. The CRC is reflected, uses polynomial 0x04C11DB7, starts from all ones and is inverted at the end. The least significant byte comes first.
- R8: A payload longer than 1518 bytes (framed length above 1530) is dropped. It causes no memory write and no buffer update. A 1518-byte payload is stored.
- R9: After the last write, `slot_wr` pulses for exactly one cycle with one bit set for the chosen buffer. In that same cycle `slot_wr_state` is 2, `slot_wr_count` equals the padded payload length plus 12, and `rx_irq` is high.
- R10: `can_rx` is high whenever `rx_hold` is high or at least one buffer state is 1.
- R11: A frame starts only while `idle` is high. `idle` returns high once the frame has been written or discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_hold | input | 1 | Receive reset: while high, new frames are discarded |
| slot_state | input | 2*NSLOTS | Buffer state fields, 2 bits per buffer, buffer 0 in bits 1:0 |
| slot_base | input | AW*NSLOTS | Buffer base addresses, buffer 0 in the low AW bits |
| start | input | 1 | Frame start strobe, taken while idle |
| start_len | input | CW | Payload length in bytes for the starting frame |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block takes the byte this cycle if in_valid is high |
| idle | output | 1 | Ready to take a start strobe |
| can_rx | output | 1 | Ready-to-receive indication |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| slot_wr | output | NSLOTS | One-hot buffer register update strobe |
| slot_wr_state | output | 2 | New state value for the strobed buffer |
| slot_wr_count | output | CW | New length value for the strobed buffer |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench uses the default parameters: four buffers, a 60-byte minimum payload and a 1530-byte framed limit. With these values the largest legal frame and the one just past the limit each take under two thousand cycles, so both sides of R8 are covered directly. Four buffers make every priority position reachable, including the case where only the last buffer is loaded and the case where pending buffers sit in front of loaded ones. The vectors cover payload lengths of zero, 59, 60 and 61, which fall on both sides of the padding boundary. One vector also inserts a gap in the byte stream.

// File: rtl/rx_slot_writer.sv
module rx_slot_writer #(
  parameter int NSLOTS      = 4,
  parameter int AW          = 32,
  parameter int CW          = 16,
  parameter int MAX_FRAMED  = 1530,
  parameter int MIN_PAYLOAD = 60
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_hold,
  input  logic [2*NSLOTS-1:0]    slot_state,
  input  logic [AW*NSLOTS-1:0]   slot_base,
  input  logic                   start,
  input  logic [CW-1:0]          start_len,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  output logic                   in_ready,
  output logic                   idle,
  output logic                   can_rx,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [7:0]             mem_wdata,
  output logic [NSLOTS-1:0]      slot_wr,
  output logic [1:0]             slot_wr_state,
  output logic [CW-1:0]          slot_wr_count,
  output logic                   rx_irq
);
  localparam int SW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
  localparam logic [CW-1:0] HDR     = CW'(8);
  localparam logic [CW-1:0] OVH     = CW'(12);
  localparam logic [CW-1:0] MINP    = CW'(MIN_PAYLOAD);
  localparam logic [CW-1:0] MAXP    = CW'(MAX_FRAMED - 12);
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [1:0]    ST_LOAD = 2'd1;
  localparam logic [1:0]    ST_PEND = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DATA, S_PAD, S_FCS, S_DONE, S_SKIP} st_t;

  st_t             st;
  logic [CW-1:0]   pos, len_q, plen_q;
  logic [AW-1:0]   base_q;
  logic [SW-1:0]   slot_q, pick;
  logic [31:0]     crc;
  logic [NSLOTS-1:0] loaded;

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  for (genvar g = 0; g < NSLOTS; g++) begin : g_ld
    assign loaded[g] = (slot_state[2*g +: 2] == ST_LOAD);
  end

  always_comb begin
    pick = '0;
    for (int i = NSLOTS - 1; i >= 0; i--)
      if (loaded[i]) pick = SW'(i);
  end

  wire drop_now = rx_hold || !(|loaded) || (start_len > MAXP);
  wire [CW-1:0] plen_now = (start_len < MINP) ? MINP : start_len;
  wire [CW-1:0] fcs_idx  = pos - HDR - plen_q;
  wire [31:0]   fcs      = ~crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pos <= '0; len_q <= '0; plen_q <= '0;
      base_q <= '0; slot_q <= '0; crc <= '1;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pos   <= '0;
          len_q <= start_len;
          if (drop_now) begin
            st <= (start_len == '0) ? S_IDLE : S_SKIP;
          end else begin
            plen_q <= plen_now;
            slot_q <= pick;
            base_q <= slot_base[AW*pick +: AW];
            crc    <= '1;
            st     <= S_PRE;
          end
        end
        S_PRE: begin
          pos <= pos + ONE;
          if (pos == HDR - ONE) st <= (len_q == '0) ? S_PAD : S_DATA;
        end
        S_DATA: if (in_valid) begin
          crc <= crc_step(crc, in_data);
          pos <= pos + ONE;
          if (pos == HDR + len_q - ONE) st <= (len_q < MINP) ? S_PAD : S_FCS;
        end
        S_PAD: begin
          crc <= crc_step(crc, 8'h00);
          pos <= pos + ONE;
          if (pos == HDR + MINP - ONE) st <= S_FCS;
        end
        S_FCS: begin
          pos <= pos + ONE;
          if (pos == HDR + plen_q + CW'(3)) st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        S_SKIP: if (in_valid) begin
          pos <= pos + ONE;
          if (pos == len_q - ONE) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      S_PRE:   mem_wdata = (pos == HDR - ONE) ? 8'hD5 : 8'h55;
      S_DATA:  mem_wdata = in_data;
      S_FCS:   mem_wdata = fcs[8*fcs_idx[1:0] +: 8];
      default: mem_wdata = 8'h00;
    endcase
  end

  assign mem_we        = (st == S_PRE) || (st == S_PAD) || (st == S_FCS) || (st == S_DATA && in_valid);
  assign mem_addr      = base_q + AW'(pos);
  assign in_ready      = (st == S_DATA) || (st == S_SKIP);
  assign idle          = (st == S_IDLE);
  assign can_rx        = rx_hold || (|loaded);
  assign rx_irq        = (st == S_DONE);
  assign slot_wr       = rx_irq ? (NSLOTS'(1) << slot_q) : '0;
  assign slot_wr_state = rx_irq ? ST_PEND : 2'd0;
  assign slot_wr_count = rx_irq ? (plen_q + OVH) : '0;
endmodule

// File: rtl/rx_slot_writer_chk.sv
module rx_slot_writer_chk #(
  parameter int NSLOTS      = 4,
  parameter int CW          = 16,
  parameter int MAX_FRAMED  = 1530,
  parameter int MIN_PAYLOAD = 60
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*NSLOTS-1:0] slot_state,
  input logic                mem_we,
  input logic [NSLOTS-1:0]   slot_wr,
  input logic [1:0]          slot_wr_state,
  input logic [CW-1:0]       slot_wr_count,
  input logic                rx_irq
);
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(slot_wr)); // R9
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |=> !rx_irq); // R9
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |-> $past(mem_we)); // R7
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_wr) |-> (slot_wr_count >= CW'(MIN_PAYLOAD + 12) && slot_wr_count <= CW'(MAX_FRAMED))); // R8
  AST_PENDING_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_wr) |-> (slot_wr_state == 2'd2)); // R9
  for (genvar g = 0; g < NSLOTS; g++) begin : g_tgt
    AST_TARGET_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      slot_wr[g] |-> (slot_state[2*g +: 2] == 2'd1)); // R1
  end
endmodule

bind rx_slot_writer rx_slot_writer_chk #(
  .NSLOTS(NSLOTS), .CW(CW), .MAX_FRAMED(MAX_FRAMED), .MIN_PAYLOAD(MIN_PAYLOAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_state(slot_state), .mem_we(mem_we),
  .slot_wr(slot_wr), .slot_wr_state(slot_wr_state), .slot_wr_count(slot_wr_count),
  .rx_irq(rx_irq)
);

// File: tb/rx_slot_writer_tb.sv
module rx_slot_writer_tb;
  localparam int NS = 4, AW = 32, CW = 16;
  localparam int NV = 10;
  // {states[7:0], hold, expected slot (7 = drop), payload length[15:0]}
  localparam logic [27:0] VEC [NV] = '{
    {8'h55, 1'b0, 3'd0, 16'd100},
    {8'h52, 1'b0, 3'd2, 16'd60},
    {8'h88, 1'b0, 3'd7, 16'd40},
    {8'h55, 1'b1, 3'd7, 16'd70},
    {8'h40, 1'b0, 3'd3, 16'd0},
    {8'h04, 1'b0, 3'd1, 16'd59},
    {8'h01, 1'b0, 3'd0, 16'd1518},
    {8'h04, 1'b0, 3'd7, 16'd1519},
    {8'h54, 1'b0, 3'd1, 16'd61},
    {8'hA6, 1'b0, 3'd1, 16'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx_hold = 1'b0;
  logic [2*NS-1:0] slot_state = '0;
  logic [AW*NS-1:0] slot_base;
  logic start = 1'b0, in_valid = 1'b0;
  logic [CW-1:0] start_len = '0;
  logic [7:0] in_data = '0;
  logic in_ready, idle, can_rx, mem_we, rx_irq;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [NS-1:0] slot_wr;
  logic [1:0] slot_wr_state;
  logic [CW-1:0] slot_wr_count;

  int total = 0, bad = 0, cyc = 0;
  int wr_cnt, bad_wr, irq_cnt, first_bad_idx;
  logic [NS-1:0] last_set;
  logic [1:0] last_state;
  logic [CW-1:0] last_cnt;
  logic [AW-1:0] cur_base;
  logic [7:0] exp_b [0:1535];

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NS; g++) begin : g_base
    assign slot_base[AW*g +: AW] = 32'h1000 * (g + 1);
  end

  rx_slot_writer u_dut (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    #2;
    if (mem_we) begin
      if (mem_addr !== cur_base + AW'(wr_cnt) || mem_wdata !== exp_b[wr_cnt]) begin
        if (bad_wr == 0) first_bad_idx = wr_cnt;
        bad_wr++;
      end
      wr_cnt++;
    end
    if (rx_irq) begin
      irq_cnt++;
      last_set = slot_wr; last_state = slot_wr_state; last_cnt = slot_wr_count;
    end
  end

  function automatic logic [7:0] pay(input int i, input int len);
    return 8'(i * 7 + len + 3);
  endfunction

  function automatic logic [31:0] crc_of(input int n);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = r[0] ^ exp_b[8 + i][b];
        r = {1'b0, r[31:1]};
        if (fb) r = r ^ 32'hEDB88320;
      end
    return ~r;
  endfunction

  task automatic build(input int len);
    int plen = (len < 60) ? 60 : len;
    logic [31:0] c;
    for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
    exp_b[7] = 8'hD5;
    for (int i = 0; i < plen; i++) exp_b[8 + i] = (i < len) ? pay(i, len) : 8'h00;
    c = crc_of(plen);
    for (int k = 0; k < 4; k++) exp_b[8 + plen + k] = c[8*k +: 8];
  endtask

  task automatic run_frame(input int len, input bit gap);
    int i = 0;
    bit gapped = 0;
    wr_cnt = 0; bad_wr = 0; irq_cnt = 0; last_set = '0; last_state = '0; last_cnt = '0;
    first_bad_idx = -1;
    @(negedge clk);
    start = 1'b1; start_len = CW'(len);
    @(negedge clk);
    start = 1'b0;
    while (i < len) begin
      if (gap && i == 5 && !gapped) begin
        in_valid = 1'b0; gapped = 1;
      end else begin
        in_valid = 1'b1; in_data = pay(i, len);
      end
      #1;
      if (in_valid && in_ready) i++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (!idle) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(idle === 1'b1 && mem_we === 1'b0 && rx_irq === 1'b0 && slot_wr === '0,
          "reset R11", {idle, mem_we, rx_irq}, 3'b100);
    check(can_rx === 1'b0, "reset can_rx R10", can_rx, 0);

    for (int v = 0; v < NV; v++) begin
      logic [27:0] e = VEC[v];
      int len = int'(e[15:0]);
      int es = int'(e[18:16]);
      int plen = (len < 60) ? 60 : len;
      bit anyld = 0;
      slot_state = e[27:20];
      rx_hold = e[19];
      for (int g = 0; g < NS; g++) if (slot_state[2*g +: 2] == 2'd1) anyld = 1;
      cur_base = (es < NS) ? 32'h1000 * (es + 1) : 32'h0;
      build(len);
      #1;
      check(can_rx === (rx_hold | anyld), $sformatf("vec%0d can_rx R10", v), can_rx, rx_hold | anyld);
      run_frame(len, v == 0);
      check(idle === 1'b1, $sformatf("vec%0d back to idle R11", v), idle, 1);
      if (es == 7) begin
        check(wr_cnt == 0, $sformatf("vec%0d drop writes R2 R3 R8", v), wr_cnt, 0);
        check(irq_cnt == 0, $sformatf("vec%0d drop irq R2 R3 R8", v), irq_cnt, 0);
      end else begin
        check(wr_cnt == plen + 12, $sformatf("vec%0d write count R5 R6", v), wr_cnt, plen + 12);
        check(bad_wr == 0, $sformatf("vec%0d frame bytes R4 R5 R6 R7 (first bad idx %0d)", v, first_bad_idx), bad_wr, 0);
        check(irq_cnt == 1, $sformatf("vec%0d irq once R9", v), irq_cnt, 1);
        check(last_set == NS'(1) << es, $sformatf("vec%0d slot choice R1", v), last_set, NS'(1) << es);
        check(last_state == 2'd2 && last_cnt == CW'(plen + 12), $sformatf("vec%0d slot update R9", v),
              last_cnt, plen + 12);
      end
    end

    slot_state = 8'h00; rx_hold = 1'b1; #1;
    check(can_rx === 1'b1, "hold only can_rx R10", can_rx, 1);
    rx_hold = 1'b0; #1;
    check(can_rx === 1'b0, "nothing loaded can_rx R10", can_rx, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule